// File: doc/BRIEF.md
# Byte-Coded Transfer-Triggered Processor Core

This core executes a program made only of data transfers. Each cycle it can accept one byte from an instruction memory port. A byte with its top bit set adds seven bits to an immediate register. Any other byte copies a word from one of eight source endpoints to one of eight destination endpoints. The endpoints are the program counter, an address register, the data RAM word at that address, the two ALU operand registers (for writes), the ALU result (for reads), the immediate register (for reads), and three general registers. The immediate register also serves as the ALU control word, so the same register picks both the arithmetic function and the test used by conditional transfers.

Jumps are transfers into the program counter. Conditional transfers take place only when the ALU test holds. The transfer from program counter to program counter is the stop code: the core raises `halted` and stops fetching until reset. The instruction port uses a valid/ready handshake. `imem_ready` is high whenever the core is not halted. A byte is consumed in the cycle where `imem_valid` and `imem_ready` are both high. In any other cycle nothing changes and no RAM write is issued, so the memory side may hold `imem_valid` low for as long as it needs. The data RAM port is a plain word-addressed port: the read is combinational, and the write is a single-cycle strobe.

Top module: `bytemove_core`

## Requirements
- R1: After reset the program counter, address register, ALU operands, immediate and the three general registers are all zero, `halted` is low and `imem_ready` is high.
- R2: A byte is accepted only in a cycle with `imem_valid` and `imem_ready` both high. In any other cycle the program counter and all registers hold, and `dmem_we` stays low.
- R3: A byte with bit 7 set is an immediate byte. If the previous accepted byte was also an immediate byte, the immediate becomes (old value shifted left by 7) with the new low 7 bits appended, truncated to the word width. Otherwise the immediate becomes the byte's low 7 bits.
- R4: A byte with bit 7 clear is a transfer: bit 6 = conditional, bits 5:3 = destination, bits 2:0 = source. The source codes are 0 program counter (the address of this byte), 1 address register, 2 RAM word at the address register, 3 immediate, 4 ALU result, 5/6/7 general registers I/J/K.
- R5: The destination codes are 0 program counter, 1 address register, 2 RAM write, 3 ALU operand A, 4 ALU operand B, 5/6/7 general registers I/J/K. A RAM write drives `dmem_we` high in the cycle the byte is accepted, with `dmem_addr` = the address register and `dmem_wdata` = the source value.
- R6: The ALU result uses function = immediate bits 2:0: 0 add, 1 and, 2 or, 3 xor, 4 pass A, 5 pass B, 6 and 7 zero.
- R7: The effective B is selected by immediate bits 6:5 (0 operand B, 1 immediate shifted right by 7, 2 operand B shifted right by 1, 3 operand B shifted left by 1). It is then inverted when bit 3 is set. Bit 4 adds a carry of one to the add.
- R8: The test uses code = immediate bits 2:0: 0 A==0, 1 B==0, 2 A>B, 3 A==B, 4 A<B, 5 B bit 0, 6 B top bit, 7 never. B here is the effective B, and comparisons are unsigned. A conditional transfer whose test is false writes nothing.
- R9: A transfer into the program counter that is performed loads the source value and does not increment. Every other accepted byte, immediate bytes included, advances the program counter by one.
- R10: A conditional transfer into the program counter whose test is false advances the program counter by one.
- R11: A transfer byte with bits 5:0 all zero is the stop code, whatever bit 6 holds. Once it is accepted, `halted` rises on the next cycle, `imem_ready` falls, the fetch address stays on the stop byte, and no further RAM write occurs until reset.
- R12: Any transfer byte ends an immediate run, so the next immediate byte starts a fresh value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | IADDR_W | Fetch address (low bits of the program counter) |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| imem_valid | input | 1 | Instruction byte is valid this cycle |
| imem_ready | output | 1 | Core can accept a byte (low once halted) |
| dmem_addr | output | DADDR_W | Data RAM word address (address register) |
| dmem_wdata | output | DATA_W | Data RAM write word |
| dmem_we | output | 1 | Data RAM write strobe |
| dmem_rdata | input | DATA_W | Data RAM read word at `dmem_addr`, combinational |
| halted | output | 1 | Stop code has executed |

## Verification
A RAM write caused by an accepted byte is visible on the data port in the same cycle. The program counter, and therefore `imem_addr`, moves one cycle after the byte is accepted, and `halted` and `imem_ready` change one cycle after the stop byte is accepted. The bench drives its inputs just after a rising edge and samples every output at the falling edge. A write is compared in the falling-edge sample of the cycle that produced it. The fetch address is compared against its value one falling edge earlier whenever the previous cycle accepted no byte. Small programs run with and without random gaps in `imem_valid`. Their expected RAM writes are queued in order and checked as they appear on the port, and the stop address is compared after `imem_ready` drops.

// File: rtl/bytemove_pkg.sv
package bytemove_pkg;

  // Source endpoint codes (instruction bits 2:0)
  typedef enum logic [2:0] {
    SRC_PC  = 3'd0,
    SRC_ADR = 3'd1,
    SRC_MEM = 3'd2,
    SRC_IMM = 3'd3,
    SRC_ALU = 3'd4,
    SRC_GI  = 3'd5,
    SRC_GJ  = 3'd6,
    SRC_GK  = 3'd7
  } src_e;

  // Destination endpoint codes (instruction bits 5:3)
  typedef enum logic [2:0] {
    DST_PC  = 3'd0,
    DST_ADR = 3'd1,
    DST_MEM = 3'd2,
    DST_OPA = 3'd3,
    DST_OPB = 3'd4,
    DST_GI  = 3'd5,
    DST_GJ  = 3'd6,
    DST_GK  = 3'd7
  } dst_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_AND   = 3'd1,
    FN_OR    = 3'd2,
    FN_XOR   = 3'd3,
    FN_PASSA = 3'd4,
    FN_PASSB = 3'd5,
    FN_ZLO   = 3'd6,
    FN_ZHI   = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    TS_AZ   = 3'd0,
    TS_BZ   = 3'd1,
    TS_AGT  = 3'd2,
    TS_AEQ  = 3'd3,
    TS_ALT  = 3'd4,
    TS_BLSB = 3'd5,
    TS_BMSB = 3'd6,
    TS_NEV  = 3'd7
  } tst_e;

  typedef enum logic [1:0] {
    BS_REG   = 2'd0,
    BS_CTLHI = 2'd1,
    BS_SHR   = 2'd2,
    BS_SHL   = 2'd3
  } bsel_e;

  localparam int GP_COUNT = 3;
  localparam int GP_BASE  = 5;
  localparam int IMM_BITS = 7;

  typedef struct packed {
    logic          is_imm;
    logic [6:0]    imm7;
    logic          cond;
    dst_e          dst;
    src_e          src;
    logic          halt;
  } op_t;

endpackage

// File: rtl/bytemove_decode.sv
module bytemove_decode
  import bytemove_pkg::*;
(
  input  logic [7:0] code,
  output op_t        op
);

  always_comb begin
    op.is_imm = code[7];
    op.imm7   = code[6:0];
    op.cond   = code[6];
    op.dst    = dst_e'(code[5:3]);
    op.src    = src_e'(code[2:0]);
    // stop code: transfer PC -> PC, conditional bit ignored
    op.halt   = ~code[7] & (code[5:0] == 6'd0);
  end

endmodule

// File: rtl/bytemove_alu.sv
module bytemove_alu
  import bytemove_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] ctl,
  output logic [DATA_W-1:0] res,
  output logic              pred
);

  localparam int MSB = DATA_W - 1;

  fn_e                fn;
  tst_e               tst;
  bsel_e              bsel;
  logic               inv;
  logic               cin;
  logic [DATA_W-1:0]  bpre;
  logic [DATA_W-1:0]  beff;

  assign fn   = fn_e'(ctl[2:0]);
  assign tst  = tst_e'(ctl[2:0]);
  assign inv  = ctl[3];
  assign cin  = ctl[4];
  assign bsel = bsel_e'(ctl[6:5]);

  // operand B pre-step
  always_comb begin
    case (bsel)
      BS_REG:   bpre = opb;
      BS_CTLHI: bpre = ctl >> IMM_BITS;
      BS_SHR:   bpre = opb >> 1;
      default:  bpre = opb << 1;
    endcase
    beff = inv ? ~bpre : bpre;
  end

  // data function
  always_comb begin
    case (fn)
      FN_ADD:   res = opa + beff + {{(DATA_W-1){1'b0}}, cin};
      FN_AND:   res = opa & beff;
      FN_OR:    res = opa | beff;
      FN_XOR:   res = opa ^ beff;
      FN_PASSA: res = opa;
      FN_PASSB: res = beff;
      default:  res = '0;
    endcase
  end

  // test predicate
  always_comb begin
    case (tst)
      TS_AZ:   pred = (opa == '0);
      TS_BZ:   pred = (beff == '0);
      TS_AGT:  pred = (opa > beff);
      TS_AEQ:  pred = (opa == beff);
      TS_ALT:  pred = (opa < beff);
      TS_BLSB: pred = beff[0];
      TS_BMSB: pred = beff[MSB];
      default: pred = 1'b0;
    endcase
  end

endmodule

// File: rtl/bytemove_regs.sv
module bytemove_regs
  import bytemove_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             step,
  input  logic                             is_imm,
  input  logic [6:0]                       imm7,
  input  logic                             wr_en,
  input  dst_e                             dst,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                adr,
  output logic [DATA_W-1:0]                opa,
  output logic [DATA_W-1:0]                opb,
  output logic [DATA_W-1:0]                imm,
  output logic [GP_COUNT-1:0][DATA_W-1:0]  gp
);

  localparam int KEEP = DATA_W - IMM_BITS;

  logic              run_q;
  logic [DATA_W-1:0] imm_q;
  logic [DATA_W-1:0] adr_q;
  logic [DATA_W-1:0] opa_q;
  logic [DATA_W-1:0] opb_q;

  // immediate builder: a run of high-bit bytes accumulates 7 bits each
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_q <= '0;
      run_q <= 1'b0;
    end else if (step) begin
      if (is_imm) begin
        imm_q <= run_q ? {imm_q[KEEP-1:0], imm7} : DATA_W'(imm7);
        run_q <= 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  // R3
  imm_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_imm && run_q |=> imm_q == {$past(imm_q[KEEP-1:0]), $past(imm7)});

  // R12
  imm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_imm && !run_q |=> imm_q == DATA_W'($past(imm7)));

  // address register and ALU operands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
    end else if (step && !is_imm && wr_en) begin
      case (dst)
        DST_ADR: adr_q <= wdata;
        DST_OPA: opa_q <= wdata;
        DST_OPB: opb_q <= wdata;
        default: ;
      endcase
    end
  end

  // general registers I, J, K
  for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
    localparam dst_e MY_DST = dst_e'(3'(GP_BASE + g));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (step && !is_imm && wr_en && dst == MY_DST)
        q <= wdata;
    end
    assign gp[g] = q;
  end

  assign adr = adr_q;
  assign opa = opa_q;
  assign opb = opb_q;
  assign imm = imm_q;

endmodule

// File: rtl/bytemove_core.sv
module bytemove_core
  import bytemove_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [7:0]         imem_data,
  input  logic               imem_valid,
  output logic               imem_ready,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               halted
);

  logic [DATA_W-1:0]                pc_q;
  logic                             halted_q;
  logic                             fire;
  logic                             do_move;
  logic                             reg_we;
  op_t                              op;
  logic [DATA_W-1:0]                srcv;
  logic [DATA_W-1:0]                adr;
  logic [DATA_W-1:0]                opa;
  logic [DATA_W-1:0]                opb;
  logic [DATA_W-1:0]                imm;
  logic [GP_COUNT-1:0][DATA_W-1:0]  gp;
  logic [DATA_W-1:0]                alu_y;
  logic                             pred;

  assign imem_ready = ~halted_q;
  assign fire       = imem_valid & imem_ready;
  assign imem_addr  = pc_q[IADDR_W-1:0];
  assign halted     = halted_q;

  bytemove_decode u_dec (
    .code (imem_data),
    .op   (op)
  );

  bytemove_alu #(.DATA_W(DATA_W)) u_alu (
    .opa  (opa),
    .opb  (opb),
    .ctl  (imm),
    .res  (alu_y),
    .pred (pred)
  );

  assign do_move = ~op.cond | pred;
  assign reg_we  = do_move & ~op.halt;

  // source endpoint mux
  always_comb begin
    case (op.src)
      SRC_PC:  srcv = pc_q;
      SRC_ADR: srcv = adr;
      SRC_MEM: srcv = dmem_rdata;
      SRC_IMM: srcv = imm;
      SRC_ALU: srcv = alu_y;
      SRC_GI:  srcv = gp[0];
      SRC_GJ:  srcv = gp[1];
      default: srcv = gp[2];
    endcase
  end

  bytemove_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (fire),
    .is_imm (op.is_imm),
    .imm7   (op.imm7),
    .wr_en  (reg_we),
    .dst    (op.dst),
    .wdata  (srcv),
    .adr    (adr),
    .opa    (opa),
    .opb    (opb),
    .imm    (imm),
    .gp     (gp)
  );

  // data RAM port
  assign dmem_addr  = adr[DADDR_W-1:0];
  assign dmem_wdata = srcv;
  assign dmem_we    = fire & ~op.is_imm & (op.dst == DST_MEM) & do_move;

  // program counter and stop state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (fire) begin
      if (op.is_imm)
        pc_q <= pc_q + 1'b1;
      else if (op.halt)
        halted_q <= 1'b1;
      else if (op.dst == DST_PC && do_move)
        pc_q <= srcv;
      else
        pc_q <= pc_q + 1'b1;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !imem_valid && !halted_q |=> $stable(imem_addr));

  // R5
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> imem_valid && imem_ready);

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !op.is_imm && !op.halt && op.dst == DST_PC && do_move
    |=> pc_q == $past(srcv));

  // R10
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !op.is_imm && !op.halt && op.cond && op.dst == DST_PC && !pred
    |=> imem_addr == IADDR_W'($past(imem_addr) + 1'b1));

  // R11
  freeze_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(imem_addr) && !dmem_we && !imem_ready);

endmodule

// File: tb/bytemove_core_test.sv
module bytemove_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int IAW = 8;
  localparam int DAW = 8;

  // endpoint codes as stated in R4/R5
  localparam logic [2:0] E_PC = 3'd0, E_ADR = 3'd1, E_MEM = 3'd2;
  localparam logic [2:0] E_IMM = 3'd3, E_OPA = 3'd3;
  localparam logic [2:0] E_ALU = 3'd4, E_OPB = 3'd4;
  localparam logic [2:0] E_I = 3'd5, E_J = 3'd6, E_K = 3'd7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [IAW-1:0] imem_addr;
  logic [7:0]     imem_data;
  logic           imem_valid = 1'b1;
  logic           imem_ready;
  logic [DAW-1:0] dmem_addr;
  logic [DW-1:0]  dmem_wdata;
  logic           dmem_we;
  logic [DW-1:0]  dmem_rdata;
  logic           halted;

  logic [7:0]  rom [256];
  logic [31:0] ram [256];
  logic        seed_we = 1'b0;
  logic [7:0]  seed_a = '0;
  logic [31:0] seed_d = '0;

  int checks = 0;
  int errs = 0;
  int ptr = 0;
  bit stall_mode = 1'b0;

  logic [7:0]  q_a [$];
  logic [31:0] q_d [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bytemove_core #(.DATA_W(DW), .IADDR_W(IAW), .DADDR_W(DAW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .imem_valid (imem_valid),
    .imem_ready (imem_ready),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .halted     (halted)
  );

  assign imem_data  = rom[imem_addr];
  assign dmem_rdata = ram[dmem_addr];

  always @(posedge clk) begin
    if (seed_we) ram[seed_a] <= seed_d;
    else if (rst_n && dmem_we) ram[dmem_addr] <= dmem_wdata;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- program assembly helpers ----
  task automatic put(input logic [7:0] b);
    rom[ptr] = b;
    ptr++;
  endtask

  task automatic mv(input logic [2:0] d, input logic [2:0] s);
    put({2'b00, d, s});
  endtask

  task automatic cmv(input logic [2:0] d, input logic [2:0] s);
    put({2'b01, d, s});
  endtask

  task automatic put_imm(input logic [31:0] v);
    int n;
    logic [34:0] t;
    t = {3'b000, v};
    n = 1;
    while (n < 5 && (t >> (7*n)) != 0) n++;
    for (int k = n - 1; k >= 0; k--) put(8'h80 | 8'((t >> (7*k)) & 35'h7F));
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    q_a.push_back(a);
    q_d.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic new_prog();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    ptr = 0;
    q_a.delete();
    q_d.delete();
    q_tag.delete();
  endtask

  task automatic seed(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    seed_we = 1'b1; seed_a = a; seed_d = d;
    @(posedge clk); #1;
    seed_we = 1'b0;
  endtask

  task automatic run_prog(input string name, input int halt_at);
    int n;
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch address after reset", imem_addr, 0);
    chk("R1 ready after reset", imem_ready, 1);
    chk("R1 halted cleared by reset", halted, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    n = 0;
    while (imem_ready && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (imem_ready) begin
      checks++; errs++;
      $display("FAIL R11 %s no halt: actual=running expected=halted", name);
    end
    chk("R11 halted high", halted, 1);
    chk("R11 stop address", imem_addr, halt_at);
    repeat (5) @(negedge clk);
    chk("R11 fetch frozen after halt", imem_addr, halt_at);
    chk("R5 all expected writes seen", q_a.size(), 0);
  endtask

  // ---- input driver for the valid line ----
  initial begin
    forever begin
      @(posedge clk); #1;
      imem_valid = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // ---- monitor / scoreboard ----
  initial begin
    logic [IAW-1:0] prev_addr;
    bit prev_fire;
    bit prev_rst;
    string tag;
    prev_addr = '0; prev_fire = 1'b0; prev_rst = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && prev_rst && !prev_fire)
        chk("R2 address held when no byte accepted", imem_addr, prev_addr);
      if (rst_n && dmem_we) begin
        if (q_a.size() == 0) begin
          checks++; errs++;
          $display("FAIL R8/R11 unexpected write actual=%0h@%0h expected=none", dmem_wdata, dmem_addr);
        end else begin
          tag = q_tag.pop_front();
          chk({tag, " addr"}, dmem_addr, q_a.pop_front());
          chk({tag, " data"}, dmem_wdata, q_d.pop_front());
        end
      end
      prev_fire = imem_valid && imem_ready;
      prev_addr = imem_addr;
      prev_rst  = rst_n;
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // ---- programs ----
  initial begin
    int jpos, tgt, halt_at, lbl;
    logic [63:0] acc;
    logic [7:0]  grp [6];
    logic [31:0] d_op [13];
    logic [31:0] d_exp [13];
    string       d_tag [13];
    logic        e_t1 [8];

    // Program 1: reset values, PC source, jump, conditional-bit stop code
    new_prog();
    mv(E_MEM, E_K);   expect_wr(8'h00, 32'h0, "R1 K and address zero");
    mv(E_MEM, E_IMM); expect_wr(8'h00, 32'h0, "R1 immediate zero");
    mv(E_MEM, E_ALU); expect_wr(8'h00, 32'h0, "R1 operands zero");
    mv(E_I, E_PC);
    put_imm(32'h70); mv(E_ADR, E_IMM); mv(E_MEM, E_I);
    expect_wr(8'h70, 32'd3, "R4 PC source gives own address");
    jpos = ptr; put(8'h80); mv(E_J, E_IMM); mv(E_PC, E_J);
    mv(E_MEM, E_I);                       // skipped by the jump
    tgt = ptr; rom[jpos] = 8'h80 | 8'(tgt);
    put_imm(32'h71); mv(E_ADR, E_IMM); mv(E_MEM, E_J);
    expect_wr(8'h71, 32'(tgt), "R9 jump target");
    put_imm(32'h2);                       // test A>B false
    halt_at = ptr; put(8'h40);            // stop code with bit 6 set (R11)
    mv(E_MEM, E_I);                       // must never execute
    stall_mode = 1'b0;
    run_prog("stop", halt_at);

    // Program 2: counted loop, sum 5..1 (R9 branch taken, R10 fall-through)
    new_prog();
    put_imm(32'd5); mv(E_K, E_IMM);
    jpos = ptr; put(8'h80); mv(E_J, E_IMM);
    lbl = ptr;
    mv(E_OPA, E_I); mv(E_OPB, E_K); put_imm(32'h0); mv(E_I, E_ALU);
    mv(E_OPA, E_K); put_imm(32'd1); mv(E_OPB, E_IMM); put_imm(32'h18); mv(E_K, E_ALU);
    mv(E_OPA, E_K); put_imm(32'h0); mv(E_OPB, E_IMM); put_imm(32'h2); cmv(E_PC, E_J);
    rom[jpos] = 8'h80 | 8'(lbl);
    put_imm(32'h10); mv(E_ADR, E_IMM); mv(E_MEM, E_I);
    expect_wr(8'h10, 32'd15, "R9 loop sum");
    put_imm(32'h11); mv(E_ADR, E_IMM); mv(E_MEM, E_K);
    expect_wr(8'h11, 32'd0, "R10 loop exit count");
    halt_at = ptr; put(8'h00);
    stall_mode = 1'b1;
    run_prog("loop", halt_at);

    // Program 3: memory copy with stalls (R4 RAM source, R5 RAM write)
    new_prog();
    seed(8'h20, 32'hDEADBEEF);
    seed(8'h21, 32'h01234567);
    seed(8'h22, 32'hCAFEF00D);
    for (int k = 0; k < 3; k++) begin
      put_imm(32'(8'h20 + k)); mv(E_ADR, E_IMM); mv(E_I, E_MEM);
      put_imm(32'(8'h30 + k)); mv(E_ADR, E_IMM); mv(E_MEM, E_I);
    end
    expect_wr(8'h30, 32'hDEADBEEF, "R5 copy word 0");
    expect_wr(8'h31, 32'h01234567, "R5 copy word 1");
    expect_wr(8'h32, 32'hCAFEF00D, "R5 copy word 2");
    put_imm(32'h21); mv(E_ADR, E_IMM); mv(E_MEM, E_MEM);
    expect_wr(8'h21, 32'h01234567, "R4 RAM to RAM");
    halt_at = ptr; put(8'h00);
    stall_mode = 1'b1;
    run_prog("copy", halt_at);

    // Program 4: long immediates (R3) and run restart (R12)
    new_prog();
    grp[0] = 8'h7F; grp[1] = 8'h01; grp[2] = 8'h23;
    grp[3] = 8'h45; grp[4] = 8'h67; grp[5] = 8'h0A;
    acc = '0;
    for (int k = 0; k < 6; k++) begin
      put(8'h80 | grp[k]);
      acc = (acc << 7) | {56'd0, grp[k]};
    end
    mv(E_I, E_IMM);
    put_imm(32'd5); mv(E_J, E_IMM);
    put_imm(32'd3); mv(E_K, E_IMM);
    put_imm(32'h72); mv(E_ADR, E_IMM); mv(E_MEM, E_I);
    expect_wr(8'h72, acc[31:0], "R3 six-byte immediate truncated");
    put_imm(32'h73); mv(E_ADR, E_IMM); mv(E_MEM, E_J);
    expect_wr(8'h73, 32'd5, "R12 first run value");
    put_imm(32'h74); mv(E_ADR, E_IMM); mv(E_MEM, E_K);
    expect_wr(8'h74, 32'd3, "R12 restarted run");
    put_imm(32'h75); mv(E_ADR, E_IMM); put(8'h85); put(8'h83); mv(E_MEM, E_IMM);
    expect_wr(8'h75, 32'h283, "R3 two-byte immediate");
    halt_at = ptr; put(8'h00);
    stall_mode = 1'b0;
    run_prog("immediate", halt_at);

    // Program 5: ALU functions (R6) and B pre-step, invert, carry (R7)
    new_prog();
    d_op[0]  = 32'h01;  d_exp[0]  = 32'h30;       d_tag[0]  = "R6 and";
    d_op[1]  = 32'h02;  d_exp[1]  = 32'hFFC;      d_tag[1]  = "R6 or";
    d_op[2]  = 32'h03;  d_exp[2]  = 32'hFCC;      d_tag[2]  = "R6 xor";
    d_op[3]  = 32'h04;  d_exp[3]  = 32'hF0;       d_tag[3]  = "R6 pass A";
    d_op[4]  = 32'h05;  d_exp[4]  = 32'hF3C;      d_tag[4]  = "R6 pass B";
    d_op[5]  = 32'h00;  d_exp[5]  = 32'h102C;     d_tag[5]  = "R6 add";
    d_op[6]  = 32'h06;  d_exp[6]  = 32'h0;        d_tag[6]  = "R6 zero";
    d_op[7]  = 32'h10;  d_exp[7]  = 32'h102D;     d_tag[7]  = "R7 add with carry";
    d_op[8]  = 32'h18;  d_exp[8]  = 32'hFFFFF1B4; d_tag[8]  = "R7 subtract";
    d_op[9]  = 32'h45;  d_exp[9]  = 32'h79E;      d_tag[9]  = "R7 B shift right";
    d_op[10] = 32'h65;  d_exp[10] = 32'h1E78;     d_tag[10] = "R7 B shift left";
    d_op[11] = 32'h1A5; d_exp[11] = 32'h3;        d_tag[11] = "R7 immediate high part";
    d_op[12] = 32'h0D;  d_exp[12] = 32'hFFFFF0C3; d_tag[12] = "R7 inverted B";
    put_imm(32'hF0); mv(E_OPA, E_IMM);
    put_imm(32'hF3C); mv(E_OPB, E_IMM);
    for (int k = 0; k < 13; k++) begin
      put_imm(32'(8'h40 + k)); mv(E_ADR, E_IMM);
      put_imm(d_op[k]); mv(E_MEM, E_ALU);
      expect_wr(8'(8'h40 + k), d_exp[k], d_tag[k]);
    end
    halt_at = ptr; put(8'h00);
    stall_mode = 1'b1;
    run_prog("alu", halt_at);

    // Program 6: test predicates and conditional writes (R8)
    new_prog();
    e_t1[0] = 0; e_t1[1] = 0; e_t1[2] = 0; e_t1[3] = 1;
    e_t1[4] = 0; e_t1[5] = 1; e_t1[6] = 0; e_t1[7] = 0;
    put_imm(32'd7); mv(E_OPA, E_IMM); mv(E_OPB, E_IMM);
    put_imm(32'h55); mv(E_J, E_IMM);
    for (int t = 0; t < 8; t++) begin
      put_imm(32'(8'h50 + t)); mv(E_ADR, E_IMM);
      put_imm(32'(t)); cmv(E_MEM, E_J);
      if (e_t1[t]) expect_wr(8'(8'h50 + t), 32'h55, "R8 test with A=B=7");
    end
    put_imm(32'h80000000); mv(E_OPB, E_IMM);
    for (int t = 2; t < 7; t++) begin
      put_imm(32'(8'h58 + t)); mv(E_ADR, E_IMM);
      put_imm(32'(t)); cmv(E_MEM, E_J);
      if (t == 4 || t == 6) expect_wr(8'(8'h58 + t), 32'h55, "R8 test with B top bit set");
    end
    put_imm(32'h0); mv(E_OPA, E_IMM);
    put_imm(32'h60); mv(E_ADR, E_IMM);
    put_imm(32'h0); cmv(E_MEM, E_J);
    expect_wr(8'h60, 32'h55, "R8 A zero test");
    put_imm(32'h0); mv(E_OPB, E_IMM);
    put_imm(32'h61); mv(E_ADR, E_IMM);
    put_imm(32'h1); cmv(E_MEM, E_J);
    expect_wr(8'h61, 32'h55, "R8 B zero test");
    halt_at = ptr; put(8'h00);
    stall_mode = 1'b0;
    run_prog("tests", halt_at);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule